// File: doc/BRIEF.md
# Approximate Tiled Array Multiplier

This block multiplies two unsigned operands of even width W. It splits each operand into 2-bit digits and multiplies every digit pair in a small 2×2 cell. Each cell gives the exact product for every digit pair except 3×3. For that pair the cell returns 7 instead of 9, so its result always fits in three bits. The cell results are shifted to their digit weight and added with an exact adder tree, which gives a 2W-bit product.

The error is deliberate and bounded. It appears only when a digit of 3 in one operand meets a digit of 3 in the other. It always makes the product smaller, never larger. The block is meant for error-tolerant datapaths such as neural-network inference or image filtering, where a smaller, lower-power multiplier is worth a small loss of accuracy.

The datapath is purely combinational. An optional output register, selected by a parameter, adds one cycle of latency.

Top module: `approx_tile_mult`

## Requirements
- R1: With the output register enabled (OUT_REG=1), `prod_o` is 0 while `rst_ni` is low, whatever the operands are.
- R2: A cell multiplies two 2-bit digits into a 3-bit result. The result equals the exact product for 15 of the 16 digit pairs, and for 3×3 it is 7 (binary 111).
- R3: Digit k of an operand is bits [2k+1:2k]. The product is the exact sum, over all digit pairs (i of `a_i`, j of `b_i`), of the cell result shifted left by 2(i+j).
- R4: When no digit pair is 3×3, the product equals the exact product `a_i*b_i`.
- R5: When either operand is zero, the product is exactly zero.
- R6: The product is never larger than the exact product. The shortfall is exactly the sum of 2·4^(i+j) over all 3×3 digit pairs (i, j).
- R7: With OUT_REG=1, `prod_o` shows the result for the operands sampled at the previous rising clock edge. With OUT_REG=0, the output follows the inputs combinationally.
- R8: For W=8 with both operands at 255, the product is 50575 (the exact product is 65025).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | W | Unsigned multiplicand |
| b_i | input | W | Unsigned multiplier |
| prod_o | output | 2W | Approximate product |

## Verification
The bench drives every pair of 8-bit operands and checks each result against a behavioural digit-by-digit model and against the exact product.

- **3×3 cell result.** A design that kept the fourth product bit of the cell, or that wrote 3×3 as 5 (XOR instead of OR in the middle bit), would fail the single-digit cases and the all-ones case.
- **Digit weighting.** Placing a 3×3 pair at the top digit separates a correct shift of 2(i+j) from a wrong shift of i+j, or from swapped digit indices.
- **Exact sum.** The operand pairs that contain no 3×3 pair show any carry lost in the adder tree.
- **Zero operands.** These must give exactly zero.
- **Shortfall.** For every pair, the difference from the exact product is compared with the closed-form shortfall.
- **Reset and latency.** The reset value and the one-cycle latency are checked by holding inputs across clock edges.

// File: rtl/apx_mult_pkg.sv
package apx_mult_pkg;
  localparam int DIGIT_W = 2;
  localparam int CELL_W  = 3;

  // true when any 2-bit digit of v equals 3
  function automatic logic has_digit3(input logic [63:0] v, input int nd);
    logic r;
    r = 1'b0;
    for (int k = 0; k < nd; k++) begin
      if (v[2*k +: 2] == 2'b11) r = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/apx_cell2x2.sv
module apx_cell2x2
  import apx_mult_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  output logic [CELL_W-1:0]  p_o
);
  // OR in the middle bit folds 3x3 onto 7 and drops the fourth bit
  assign p_o[0] = a_i[0] & b_i[0];
  assign p_o[1] = (a_i[1] & b_i[0]) | (a_i[0] & b_i[1]);
  assign p_o[2] = a_i[1] & b_i[1];
endmodule

// File: rtl/apx_pp_array.sv
module apx_pp_array
  import apx_mult_pkg::*;
#(
  parameter int W = 8,
  localparam int ND = W / DIGIT_W,
  localparam int NT = ND * ND,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]          a_i,
  input  logic [W-1:0]          b_i,
  output logic [NT-1:0][PW-1:0] terms_o
);
  for (genvar i = 0; i < ND; i++) begin : g_row
    for (genvar j = 0; j < ND; j++) begin : g_col
      localparam int SH = DIGIT_W * (i + j);
      logic [CELL_W-1:0] cp;
      apx_cell2x2 u_cell (
        .a_i (a_i[DIGIT_W*i +: DIGIT_W]),
        .b_i (b_i[DIGIT_W*j +: DIGIT_W]),
        .p_o (cp)
      );
      assign terms_o[i*ND+j] = PW'(cp) << SH;
    end
  end
endmodule

// File: rtl/apx_sum_tree.sv
module apx_sum_tree #(
  parameter int N  = 16,
  parameter int PW = 16,
  localparam int LVL = (N > 1) ? $clog2(N) : 0,
  localparam int NP  = 1 << LVL
) (
  input  logic [N-1:0][PW-1:0] terms_i,
  output logic [PW-1:0]        sum_o
);
  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int CNT = NP >> l;
    logic [PW-1:0] s [CNT];
    for (genvar k = 0; k < CNT; k++) begin : g_node
      if (l == 0) begin : g_leaf
        if (k < N) begin : g_in
          assign s[k] = terms_i[k];
        end else begin : g_pad
          assign s[k] = '0;
        end
      end else begin : g_add
        assign s[k] = g_lvl[l-1].s[2*k] + g_lvl[l-1].s[2*k+1];
      end
    end
  end
  assign sum_o = g_lvl[LVL].s[0];
endmodule

// File: rtl/approx_tile_mult.sv
module approx_tile_mult
  import apx_mult_pkg::*;
#(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int ND = W / DIGIT_W,
  localparam int NT = ND * ND,
  localparam int PW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] prod_o
);
  logic [NT-1:0][PW-1:0] terms;
  logic [PW-1:0]         res_d;

  apx_pp_array #(.W(W)) u_pp (
    .a_i     (a_i),
    .b_i     (b_i),
    .terms_o (terms)
  );

  apx_sum_tree #(.N(NT), .PW(PW)) u_sum (
    .terms_i (terms),
    .sum_o   (res_d)
  );

  if (OUT_REG) begin : g_reg
    logic [PW-1:0] prod_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q <= '0;
      else         prod_q <= res_d;
    end
    assign prod_o = prod_q;
  end else begin : g_comb
    assign prod_o = res_d;
  end

  // reference checks against the exact product
  logic [PW-1:0] exact;
  logic [PW-1:0] deficit;
  assign exact   = PW'(a_i) * PW'(b_i);
  assign deficit = exact - res_d;

  a_r5_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |-> res_d == '0);

  a_r4_exact_no_33: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!has_digit3(64'(a_i), ND) || !has_digit3(64'(b_i), ND)) |-> res_d == exact);

  a_r6_not_above_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_d <= exact);

  a_r6_even_shortfall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deficit[0] == 1'b0);
endmodule

// File: tb/approx_tile_mult_tb_top.sv
module approx_tile_mult_tb_top;
  localparam int W  = 8;
  localparam int ND = W / 2;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic [W-1:0]   a_i, b_i;
  logic [2*W-1:0] prod_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  approx_tile_mult #(.W(W), .OUT_REG(1'b1)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic int ref_apx(input int a, input int b);
    int s = 0;
    for (int i = 0; i < ND; i++) begin
      for (int j = 0; j < ND; j++) begin
        int da = (a >> (2*i)) & 3;
        int db = (b >> (2*j)) & 3;
        int cp = (da == 3 && db == 3) ? 7 : da * db;
        s += cp << (2*(i+j));
      end
    end
    return s;
  endfunction

  function automatic int ref_short(input int a, input int b);
    int s = 0;
    for (int i = 0; i < ND; i++) begin
      for (int j = 0; j < ND; j++) begin
        if (((a >> (2*i)) & 3) == 3 && ((b >> (2*j)) & 3) == 3)
          s += 2 << (2*(i+j));
      end
    end
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive on negedge, sample half a cycle after the capturing edge
  task automatic apply(input int a, input int b);
    @(negedge clk_i);
    a_i = W'(a);
    b_i = W'(b);
    @(posedge clk_i);
    #5;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0;
    a_i = '0;
    b_i = '0;
    repeat (2) @(negedge clk_i);
    a_i = '1;
    b_i = '1;
    @(posedge clk_i);
    #5;
    check("R1 reset", int'(prod_o), 0);
    @(negedge clk_i);
    check("R1 reset hold", int'(prod_o), 0);
    rst_ni = 1'b1;

    // R2 single-digit cell cases
    apply(3, 3); check("R2 3x3", int'(prod_o), 7);
    apply(2, 3); check("R2 2x3", int'(prod_o), 6);
    apply(3, 2); check("R2 3x2", int'(prod_o), 6);
    apply(1, 1); check("R2 1x1", int'(prod_o), 1);

    // R3 weighting of a 3x3 pair at digit 3 / digit 0
    apply(8'hC0, 8'h03); check("R3 top digit", int'(prod_o), 7 << 6);
    apply(8'h03, 8'hC0); check("R3 swapped", int'(prod_o), 7 << 6);
    check("R6 top digit shortfall", 576 - (7 << 6), 2 << 6);

    // R8 all ones
    apply(255, 255); check("R8 all ones", int'(prod_o), 50575);

    // R7 one-cycle latency: output holds until the next edge
    apply(5, 6);
    @(negedge clk_i);
    a_i = 8'd7;
    b_i = 8'd9;
    #1;
    check("R7 hold before edge", int'(prod_o), 30);
    @(posedge clk_i);
    #5;
    check("R7 update after edge", int'(prod_o), ref_apx(7, 9));

    // exhaustive sweep
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        apply(x, y);
        check("R3 model", int'(prod_o), ref_apx(x, y));
        check("R6 shortfall", x * y - int'(prod_o), ref_short(x, y));
        if (ref_short(x, y) == 0) check("R4 exact", int'(prod_o), x * y);
        if (x == 0 || y == 0) check("R5 zero", int'(prod_o), 0);
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule